// File: doc/BRIEF.md
# Startup Lane Word Aligner

This block lines up two deserialized sample streams that arrive in one clock domain at the same word rate but with different sample densities: a fast lane carrying 64 samples per word and a slow lane carrying 8 samples per word. Each slow sample therefore covers 8 consecutive fast samples. After the clocks lock, the two lanes have a fixed but unknown offset between them. Calibration runs once, right after reset, while a shared sync pulse is steered onto both lanes through an external selector.

During calibration the block finds the first rising edge in each stream and counts across word boundaries. It computes the offset in fast-sample units as the fast edge index minus eight times the slow edge index. It then programs a delay of up to four words on the fast stream: a word tap plus a bit shift. The slow stream runs through a fixed two-word delay, so both positive and negative offsets can be absorbed. When the offset is known and lies in range, the block reports completion and releases the selector back to normal traffic. A missing edge or an offset outside the delay range ends calibration with an error.

Top module: `lane_word_aligner`

## Requirements
- R1: While reset is low and in the first cycle after it, `cal_done` and `cal_error` are 0, `mux_cal_sel` is 1 and `offset` is 0.
- R2: A rising edge is a sample at 1 whose preceding sample is 0. Bit 0 of a word is its earliest sample. The sample before word 0 counts as 1, so a pulse that is already high at startup is not taken as an edge.
- R3: Edge search runs across word boundaries. The last bit (bit 63 fast, bit 7 slow) of the previous word precedes bit 0 of the next word.
- R4: Edge indices count from word 0 (the first word taken after reset): index = word number × word width + bit position. `offset` is the fast index minus 8 × the slow index, as a two's-complement value.
- R5: When the later of the two edges falls in word k, `cal_done` (or `cal_error` on an out-of-range offset) rises in the cycle after the clock edge that takes word k+1.
- R6: After calibration completes, each group of fast output bits 8j..8j+7 carries the same signal samples as slow output bit j of the same output word.
- R7: An offset from -127 to +128 completes calibration with `cal_done`. Any other offset raises `cal_error` and leaves `cal_done` at 0.
- R8: If both edges have not been found in words 0 to TIMEOUT_WORDS-1, `cal_error` rises after the clock edge that takes word TIMEOUT_WORDS, and `offset` stays 0.
- R9: `mux_cal_sel` is 1 until `cal_done` rises and 0 from then on. On error it stays 1.
- R10: `cal_done`, `cal_error` and `offset` hold until the next reset. Later edges on either lane have no effect on them.
- R11: Before calibration completes, both outputs are the input words delayed by three clock cycles (a two-word centre delay plus the output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock shared by both lanes |
| rst_n | input | 1 | Synchronous active-low reset, starts calibration when released |
| fast_word | input | FAST_W | Fast-lane word, bit 0 earliest |
| slow_word | input | FAST_W/RATIO | Slow-lane word, bit 0 earliest |
| aligned_fast | output | FAST_W | Fast stream after offset correction |
| aligned_slow | output | FAST_W/RATIO | Slow stream after the fixed centre delay |
| mux_cal_sel | output | 1 | 1 steers the sync pulse onto the lane, 0 returns normal traffic |
| cal_done | output | 1 | Calibration finished with a usable offset |
| cal_error | output | 1 | Calibration failed: edge missing or offset out of range |
| offset | output | $clog2(TIMEOUT_WORDS+1)+$clog2(FAST_W)+1 | Measured signed offset in fast samples |

## Verification
A wrong edge position or a wrong word count shows up directly in `offset` in the cycle in which `cal_done` or `cal_error` rises. It also shows up a few words later as a mismatch between the fast and slow output bit groups. A stuck or mis-sequenced state shows up as the flag rising one cycle early or late against the word index of the later edge, or as the selector not following the done flag. A bad tap in the delay line is caught by comparing every output word after lock with the slow output, and before lock with the input delayed by three cycles.

// File: rtl/lane_align_pkg.sv
// Shared types for the lane word aligner.
package lane_align_pkg;
    // Calibration phase of the aligner.
    typedef enum logic [1:0] {
        CAL_SEARCH = 2'd0,
        CAL_LOCKED = 2'd1,
        CAL_FAILED = 2'd2
    } cal_state_e;
endpackage

// File: rtl/lane_edge_find.sv
// Finds the earliest rising edge inside one word.
// Assumes bit 0 is the earliest sample; prev_bit is the last sample
// of the previous word. The lowest rising position wins.
module lane_edge_find #(
    parameter int W     = 64,
    parameter int POS_W = $clog2(W)
) (
    input  logic [W-1:0]     word,
    input  logic             prev_bit,
    output logic             hit,
    output logic [POS_W-1:0] pos
);
    logic [W-1:0] rise;

    // Marks each sample at 1 whose predecessor is 0.
    always_comb begin
        rise = word & ~{word[W-2:0], prev_bit};
    end

    // Priority pick of the earliest rising sample.
    always_comb begin
        hit = |rise;
        pos = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (rise[i]) pos = POS_W'(i);
        end
    end
endmodule

// File: rtl/fast_delay_line.sv
// Variable delay of 0 to DEPTH*W-1 samples on a word stream.
// Keeps DEPTH past words, joins them with the current word and picks
// a W-bit window; the result is registered (one extra cycle).
module fast_delay_line #(
    parameter int W     = 64,
    parameter int DEPTH = 4,
    parameter int SH_W  = $clog2(DEPTH * W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] shift,
    output logic [W-1:0]    dout
);
    localparam int BIG_W  = (DEPTH + 1) * W;
    localparam int BASE_W = $clog2(BIG_W);

    logic [W-1:0]      hist [DEPTH];
    logic [BIG_W-1:0]  big;
    logic [BASE_W-1:0] base;

    // Word history: hist[0] is one word old, hist[DEPTH-1] the oldest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) hist[k] <= '0;
        end else begin
            hist[0] <= din;
            for (int k = 1; k < DEPTH; k++) hist[k] <= hist[k-1];
        end
    end

    // Joined sample window, oldest word in the low bits.
    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_join
            assign big[(DEPTH-1-k)*W +: W] = hist[k];
        end
    endgenerate
    assign big[DEPTH*W +: W] = din;

    // Window start moves toward older samples as the shift grows.
    always_comb begin
        base = BASE_W'(DEPTH * W) - BASE_W'(shift);
    end

    // Registered window output.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= '0;
        else        dout <= big[base +: W];
    end
endmodule

// File: rtl/slow_delay_line.sv
// Fixed delay of STAGES words plus one output register.
module slow_delay_line #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    // Shift register of whole words, then the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
            dout <= '0;
        end else begin
            pipe[0] <= din;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
            dout <= pipe[STAGES-1];
        end
    end
endmodule

// File: rtl/lane_word_aligner.sv
// One-shot calibrator that aligns a fast and a slow sampled lane.
// Assumes both lanes deliver one word per clock in this domain, bit 0
// earliest, and RATIO fast samples per slow sample. After reset it
// searches for the first rising edge on each lane and measures the
// offset = fast index - RATIO * slow index. It then sets the fast delay
// to CENTRE - offset, while the slow lane keeps a fixed CENTRE delay.
module lane_word_aligner #(
    parameter int FAST_W        = 64,
    parameter int RATIO         = 8,
    parameter int DLY_WORDS     = 4,
    parameter int TIMEOUT_WORDS = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [FAST_W-1:0]         fast_word,
    input  logic [FAST_W/RATIO-1:0]   slow_word,
    output logic [FAST_W-1:0]         aligned_fast,
    output logic [FAST_W/RATIO-1:0]   aligned_slow,
    output logic                      mux_cal_sel,
    output logic                      cal_done,
    output logic                      cal_error,
    output logic signed [$clog2(TIMEOUT_WORDS+1)+$clog2(FAST_W):0] offset
);
    import lane_align_pkg::*;

    localparam int SLOW_W  = FAST_W / RATIO;
    localparam int FP_W    = $clog2(FAST_W);
    localparam int SP_W    = $clog2(SLOW_W);
    localparam int CNT_W   = $clog2(TIMEOUT_WORDS + 1);
    localparam int FIDX_W  = CNT_W + FP_W;
    localparam int SIDX_W  = CNT_W + SP_W;
    localparam int OFS_W   = FIDX_W + 1;
    localparam int SH_W    = $clog2(DLY_WORDS * FAST_W);
    localparam int CENTRE  = (DLY_WORDS / 2) * FAST_W;
    localparam int MAX_SH  = DLY_WORDS * FAST_W - 1;
    localparam int OFS_MIN = CENTRE - MAX_SH;
    localparam int OFS_MAX = CENTRE;

    cal_state_e               state;
    logic [CNT_W-1:0]         wcnt;
    logic                     f_found, s_found;
    logic [FIDX_W-1:0]        f_idx;
    logic [SIDX_W-1:0]        s_idx;
    logic                     prev_f, prev_s;
    logic                     f_hit, s_hit;
    logic [FP_W-1:0]          f_pos;
    logic [SP_W-1:0]          s_pos;
    logic signed [OFS_W-1:0]  ofs_q;
    logic signed [OFS_W-1:0]  meas;
    logic signed [OFS_W-1:0]  f_ext, s_ext;
    logic                     in_range;
    logic [SH_W-1:0]          shift_q, shift_calc;

    lane_edge_find #(.W(FAST_W), .POS_W(FP_W)) u_fast_edge (
        .word(fast_word), .prev_bit(prev_f), .hit(f_hit), .pos(f_pos)
    );

    lane_edge_find #(.W(SLOW_W), .POS_W(SP_W)) u_slow_edge (
        .word(slow_word), .prev_bit(prev_s), .hit(s_hit), .pos(s_pos)
    );

    // Offset arithmetic and range test on the captured edge indices.
    always_comb begin
        f_ext      = OFS_W'(f_idx);
        s_ext      = OFS_W'(s_idx) * OFS_W'(RATIO);
        meas       = f_ext - s_ext;
        in_range   = (int'(meas) >= OFS_MIN) && (int'(meas) <= OFS_MAX);
        shift_calc = SH_W'(CENTRE - int'(meas));
    end

    // Calibration sequence: search, then lock or fail until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= CAL_SEARCH;
            wcnt    <= '0;
            f_found <= 1'b0;
            s_found <= 1'b0;
            f_idx   <= '0;
            s_idx   <= '0;
            prev_f  <= 1'b1;
            prev_s  <= 1'b1;
            ofs_q   <= '0;
            shift_q <= SH_W'(CENTRE);
        end else if (state == CAL_SEARCH) begin
            prev_f <= fast_word[FAST_W-1];
            prev_s <= slow_word[SLOW_W-1];
            if (wcnt != CNT_W'(TIMEOUT_WORDS)) wcnt <= wcnt + 1'b1;
            if (!f_found && f_hit) begin
                f_found <= 1'b1;
                f_idx   <= {wcnt, f_pos};
            end
            if (!s_found && s_hit) begin
                s_found <= 1'b1;
                s_idx   <= {wcnt, s_pos};
            end
            if (f_found && s_found) begin
                ofs_q <= meas;
                if (in_range) begin
                    shift_q <= shift_calc;
                    state   <= CAL_LOCKED;
                end else begin
                    state   <= CAL_FAILED;
                end
            end else if (wcnt == CNT_W'(TIMEOUT_WORDS)) begin
                state <= CAL_FAILED;
            end
        end
    end

    fast_delay_line #(.W(FAST_W), .DEPTH(DLY_WORDS), .SH_W(SH_W)) u_fast_dly (
        .clk(clk), .rst_n(rst_n), .din(fast_word), .shift(shift_q),
        .dout(aligned_fast)
    );

    slow_delay_line #(.W(SLOW_W), .STAGES(DLY_WORDS / 2)) u_slow_dly (
        .clk(clk), .rst_n(rst_n), .din(slow_word), .dout(aligned_slow)
    );

    // Status outputs decoded from the phase.
    always_comb begin
        cal_done    = (state == CAL_LOCKED);
        cal_error   = (state == CAL_FAILED);
        mux_cal_sel = (state != CAL_LOCKED);
        offset      = ofs_q;
    end
endmodule

// File: rtl/lane_word_aligner_chk.sv
// Property checker for lane_word_aligner, attached by bind.
module lane_word_aligner_chk #(
    parameter int FAST_W        = 64,
    parameter int RATIO         = 8,
    parameter int DLY_WORDS     = 4,
    parameter int TIMEOUT_WORDS = 32
) (
    input logic clk,
    input logic rst_n,
    input logic mux_cal_sel,
    input logic cal_done,
    input logic cal_error,
    input logic signed [$clog2(TIMEOUT_WORDS+1)+$clog2(FAST_W):0] offset
);
    localparam int CENTRE = (DLY_WORDS / 2) * FAST_W;
    localparam int LOW    = CENTRE - (DLY_WORDS * FAST_W - 1);

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!cal_done && !cal_error && mux_cal_sel && offset == 0)); // R1
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> cal_done); // R10
    AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cal_error |=> cal_error); // R10
    AST_OFFSET_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done || cal_error) |=> $stable(offset)); // R10
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_done && cal_error)); // R7
    AST_OFFSET_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> (int'(offset) >= LOW && int'(offset) <= CENTRE)); // R7
    AST_SEL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> !mux_cal_sel); // R9
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_done |-> mux_cal_sel); // R9
endmodule

bind lane_word_aligner lane_word_aligner_chk #(
    .FAST_W(FAST_W), .RATIO(RATIO), .DLY_WORDS(DLY_WORDS),
    .TIMEOUT_WORDS(TIMEOUT_WORDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mux_cal_sel(mux_cal_sel),
    .cal_done(cal_done), .cal_error(cal_error), .offset(offset)
);

// File: tb/lane_word_aligner_bench.sv
`timescale 1ns/1ps
// Directed bench for lane_word_aligner: one task per scenario.
module lane_word_aligner_bench;
    localparam int FW  = 64;
    localparam int SW  = 8;
    localparam int TMO = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [FW-1:0]      fast_word = '0;
    logic [SW-1:0]      slow_word = '0;
    logic [FW-1:0]      aligned_fast;
    logic [SW-1:0]      aligned_slow;
    logic               mux_cal_sel, cal_done, cal_error;
    logic signed [12:0] offset;

    int checks = 0;
    int fails  = 0;
    bit tv [1024];
    int cur_d;
    bit kill_slow;

    always #2.5 clk = ~clk;

    lane_word_aligner #(.FAST_W(FW), .RATIO(8), .DLY_WORDS(4), .TIMEOUT_WORDS(TMO)) u_lane_word_aligner (
        .clk(clk), .rst_n(rst_n), .fast_word(fast_word), .slow_word(slow_word),
        .aligned_fast(aligned_fast), .aligned_slow(aligned_slow),
        .mux_cal_sel(mux_cal_sel), .cal_done(cal_done), .cal_error(cal_error),
        .offset(offset)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit fast_sample(input int n);
        int r = n - cur_d;
        if (r < 0) return 1'b0;
        return tv[r / 8];
    endfunction

    function automatic logic [FW-1:0] fast_at(input int w);
        logic [FW-1:0] v;
        for (int b = 0; b < FW; b++) v[b] = fast_sample(w * FW + b);
        return v;
    endfunction

    function automatic logic [SW-1:0] slow_at(input int w);
        logic [SW-1:0] v;
        for (int b = 0; b < SW; b++) v[b] = kill_slow ? 1'b0 : tv[w * SW + b];
        return v;
    endfunction

    // Builds the shared signal: quiet, pulse at s, then pseudo-random data.
    task automatic fill_t(input int s, input bit init_high);
        logic [31:0] lf = 32'h1234_5679 ^ 32'(s);
        for (int m = 0; m < 1024; m++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            if (m < s)          tv[m] = init_high && (m < 3);
            else if (m < s + 4) tv[m] = 1'b1;
            else                tv[m] = lf[0];
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fast_word = '0;
        slow_word = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic test_reset();
        do_reset();
        check(!cal_done && !cal_error, "R1", "flags in reset", {cal_done, cal_error}, 0);
        check(mux_cal_sel == 1'b1, "R1", "selector in reset", mux_cal_sel, 1);
        check(offset == 0, "R1", "offset in reset", offset, 0);
    endtask

    // mode 0: lock, 1: range error, 2: timeout
    task automatic run_case(input string req, input int s, input int d,
                            input bit init_high, input bit no_slow,
                            input int mode, input int nwords);
        int f, k, exp_it;
        bit ok;
        cur_d = d;
        kill_slow = no_slow;
        fill_t(s, init_high);
        do_reset();
        rst_n = 1'b1;
        fast_word = fast_at(0);
        slow_word = slow_at(0);
        f = 8 * s + d;
        k = (f / FW > s / SW) ? f / FW : s / SW;
        exp_it = (mode == 2) ? TMO + 1 : k + 2;
        for (int i = 1; i <= nwords; i++) begin
            @(negedge clk);
            if (i == 1) begin
                check(!cal_done && !cal_error && mux_cal_sel && offset == 0,
                      "R1", "first cycle after reset", {cal_done, cal_error, mux_cal_sel}, 3'b001);
            end
            if (i == exp_it - 1) begin
                check(!cal_done && !cal_error, mode == 2 ? "R8" : "R5",
                      "flags one cycle early", {cal_done, cal_error}, 0);
            end
            if (i == exp_it) begin
                if (mode == 0) begin
                    check(cal_done && !cal_error, req, "done flag", {cal_done, cal_error}, 2'b10);
                    check(int'(offset) == d, "R4", "measured offset", 64'(offset), 64'(d));
                    check(mux_cal_sel == 1'b0, "R9", "selector released", mux_cal_sel, 0);
                end else begin
                    check(!cal_done && cal_error, req, "error flag", {cal_done, cal_error}, 2'b01);
                    check(int'(offset) == ((mode == 1) ? d : 0), req, "offset on error",
                          64'(offset), (mode == 1) ? 64'(d) : 0);
                    check(mux_cal_sel == 1'b1, "R9", "selector held on error", mux_cal_sel, 1);
                end
            end
            if (i >= 3 && i < exp_it) begin
                check(aligned_fast == fast_at(i - 3) && aligned_slow == slow_at(i - 3),
                      "R11", "centre delay before lock", aligned_fast, fast_at(i - 3));
            end
            if (mode == 0 && i >= exp_it + 2) begin
                ok = 1'b1;
                for (int j = 0; j < SW; j++)
                    for (int b = 0; b < 8; b++)
                        if (aligned_fast[8*j+b] != aligned_slow[j]) ok = 1'b0;
                check(ok, "R6", "fast groups match slow bits", aligned_fast, 64'(aligned_slow));
            end
            fast_word = fast_at(i);
            slow_word = slow_at(i);
        end
        // R10: later data edges left everything in place
        check(cal_done == (mode == 0) && cal_error == (mode != 0), "R10",
              "final flags", {cal_done, cal_error}, (mode == 0) ? 2'b10 : 2'b01);
        check(int'(offset) == ((mode == 2) ? 0 : d), "R10", "final offset",
              64'(offset), (mode == 2) ? 0 : 64'(d));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        test_reset();                               // R1
        run_case("R4", 5, 0, 1'b0, 1'b0, 0, 24);    // zero offset
        run_case("R4", 13, 37, 1'b0, 1'b0, 0, 24);  // positive offset
        run_case("R4", 30, -100, 1'b0, 1'b0, 0, 24);// negative offset
        run_case("R7", 2, 128, 1'b0, 1'b0, 0, 24);  // upper bound locks
        run_case("R7", 20, -127, 1'b0, 1'b0, 0, 24);// lower bound locks
        run_case("R7", 2, 129, 1'b0, 1'b0, 1, 20);  // above range fails
        run_case("R7", 20, -128, 1'b0, 1'b0, 1, 20);// below range fails
        run_case("R3", 16, 0, 1'b0, 1'b0, 0, 24);   // edges at bit 0 of word 2
        run_case("R2", 10, -20, 1'b1, 1'b0, 0, 24); // high at start not an edge
        run_case("R8", 5, 0, 1'b0, 1'b1, 2, 40);    // slow edge never comes
        run_case("R5", 251, 0, 1'b0, 1'b0, 0, 45);  // edges in last searched word
        finish_run();
    end
endmodule